// File: doc/BRIEF.md
# Programmable Bus Strobe Stretcher

This block sits between a host-side bus master and a port that serves peripherals of different speeds. The requester presents an address, write data and a direction. The block then runs one access on the peripheral side. That access is an active-low strobe framed by a programmable stretch factor n, held in a small control register. Each access lasts 2*n clock cycles: n cycles with the strobe high, then n cycles with the strobe low. A slow peripheral therefore gets n cycles to respond. On the last strobe-low cycle the block captures the peripheral's read data and then raises a one-cycle done pulse.

The sequencer has three named states:
- `ST_IDLE`: waiting for a request.
- `ST_LEAD`: strobe high, n cycles.
- `ST_ACTIVE`: strobe low, n cycles.

It moves between them on three named transitions:
- T_ACCEPT (`ST_IDLE` to `ST_LEAD`): a request is seen while idle.
- T_ASSERT (`ST_LEAD` to `ST_ACTIVE`): the lead count expires.
- T_RELEASE (`ST_ACTIVE` to `ST_IDLE`): the active count expires; read data is captured and done follows.

The factor is copied into the access at T_ACCEPT, so a register write made at any later point only shapes the next access.

Top module: `strobe_stretcher`

## Requirements
- R1: After reset, per_strobe_n is 1, busy is 0, done is 0, and the stored factor is 1.
- R2: A request is accepted at the clock edge where req_valid is 1 and busy is 0. After that edge the strobe stays high for n cycles and then goes low for n cycles, all in one contiguous run.
- R3: A stored factor of 0 behaves exactly like a factor of 1, giving a 2-cycle access.
- R4: The factor used by an access is the value stored at its acceptance edge. A cfg_we write on that same edge, or during the access, takes effect only from the next access.
- R5: busy is 1 for exactly the 2*n cycles of an access. A req_valid seen while busy is ignored and starts no access.
- R6: per_rdata is captured at the edge that ends the last strobe-low cycle. done is 1 for exactly one cycle after that edge, with rdata carrying the captured value. rdata keeps that value until the next capture.
- R7: per_addr, per_wdata and per_write hold the values accepted with the request, unchanged for the whole access.
- R8: per_strobe_n is 0 only while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all stretch timing counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the stretch-factor register |
| cfg_factor | input | FACT_W | New stretch factor n |
| req_valid | input | 1 | Access request, taken only while idle |
| req_write | input | 1 | Direction: 1 write, 0 read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress; requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| per_strobe_n | output | 1 | Active-low access strobe to the peripheral |
| per_write | output | 1 | Direction held for the access |
| per_addr | output | ADDR_W | Address held for the access |
| per_wdata | output | DATA_W | Write data held for the access |
| per_rdata | input | DATA_W | Read data from the peripheral |

## Verification
Two events can land on the same edge: a factor-register write and the acceptance of a request. The bench drives cfg_we and req_valid in the same cycle, with a new factor that differs from the stored one. It then judges the outcome by counting strobe-low cycles: that access must use the old factor and the following access the new one. A second collision is tested too: a register write plus a spurious request in the middle of an access. The bench checks that the held address does not move, and that no extra access begins after done.

// File: rtl/strb_pkg.sv
package strb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/strb_factor_reg.sv
module strb_factor_reg #(
    parameter int FACT_W  = 4,
    parameter int RST_VAL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FACT_W-1:0] wr_val,
    output logic [FACT_W-1:0] eff
);
    logic [FACT_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= FACT_W'(RST_VAL);
        else if (wr_en)
            q <= wr_val;
    end

    // zero is clamped to the shortest legal stretch
    always_comb eff = (q == '0) ? FACT_W'(1) : q;
endmodule

// File: rtl/strb_phase_cnt.sv
module strb_phase_cnt #(
    parameter int FACT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FACT_W-1:0] len,
    output logic              last
);
    logic [FACT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - FACT_W'(1);
        else if (cnt != '0)
            cnt <= cnt - FACT_W'(1);
    end

    always_comb last = (cnt == '0);
endmodule

// File: rtl/strb_hold.sv
module strb_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cap,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              per_write,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_write <= 1'b0;
            per_addr  <= '0;
            per_wdata <= '0;
        end else if (take) begin
            per_write <= req_write;
            per_addr  <= req_addr;
            per_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (cap)
            rdata <= per_rdata;
    end
endmodule

// File: rtl/strobe_stretcher.sv
module strobe_stretcher
    import strb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int FACT_W     = 4,
    parameter int RST_FACTOR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FACT_W-1:0] cfg_factor,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              per_strobe_n,
    output logic              per_write,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata
);
    seq_state_t        state, state_d;
    logic [FACT_W-1:0] fac_eff;
    logic [FACT_W-1:0] len_q;
    logic [FACT_W-1:0] load_len;
    logic              cnt_last;
    logic              accept;
    logic              t_assert;
    logic              t_release;
    logic              cnt_load;
    logic              done_q;

    strb_factor_reg #(.FACT_W(FACT_W), .RST_VAL(RST_FACTOR)) u_fac (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_val (cfg_factor),
        .eff    (fac_eff)
    );

    always_comb begin
        accept    = req_valid && (state == ST_IDLE);
        t_assert  = (state == ST_LEAD) && cnt_last;
        t_release = (state == ST_ACTIVE) && cnt_last;
        cnt_load  = accept || t_assert;
        load_len  = accept ? fac_eff : len_q;
    end

    strb_phase_cnt #(.FACT_W(FACT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .len   (load_len),
        .last  (cnt_last)
    );

    strb_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cap       (t_release),
        .per_rdata (per_rdata),
        .per_write (per_write),
        .per_addr  (per_addr),
        .per_wdata (per_wdata),
        .rdata     (rdata)
    );

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (accept)    state_d = ST_LEAD;
            ST_LEAD:   if (t_assert)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (t_release) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            len_q  <= FACT_W'(1);
            done_q <= 1'b0;
        end else begin
            state  <= state_d;
            done_q <= t_release;
            if (accept)
                len_q <= fac_eff;
        end
    end

    always_comb begin
        busy         = (state != ST_IDLE);
        per_strobe_n = (state != ST_ACTIVE);
        done         = done_q;
    end
endmodule

// File: rtl/strobe_stretcher_chk.sv
module strobe_stretcher_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              per_strobe_n,
    input logic              per_write,
    input logic [ADDR_W-1:0] per_addr,
    input logic [DATA_W-1:0] per_wdata
);
    // R8
    strobe_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !per_strobe_n |-> busy);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!per_strobe_n) && !busy);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(per_addr) && $stable(per_wdata) && $stable(per_write)));

    // R2
    lead_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> per_strobe_n);
endmodule

bind strobe_stretcher strobe_stretcher_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .per_strobe_n (per_strobe_n),
    .per_write    (per_write),
    .per_addr     (per_addr),
    .per_wdata    (per_wdata)
);

// File: tb/sim_strobe_stretcher.sv
module sim_strobe_stretcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_factor = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, per_strobe_n, per_write;
    logic [15:0] rdata, per_addr, per_wdata;
    logic [15:0] per_rdata = '0;
    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;

    strobe_stretcher u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_factor(cfg_factor),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .per_strobe_n(per_strobe_n), .per_write(per_write), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    // vector table: programmed factor, effective n, direction, address, wdata, rdata
    localparam int NV = 6;
    localparam logic [3:0]  V_FAC [NV] = '{4'd1, 4'd3, 4'd0, 4'd7, 4'd15, 4'd2};
    localparam int          V_N   [NV] = '{1, 3, 1, 7, 15, 2};
    localparam logic        V_WR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [15:0] V_AD  [NV] = '{16'h0010, 16'hA5A5, 16'h0001, 16'h7FFE, 16'hFFFF, 16'h1234};
    localparam logic [15:0] V_WD  [NV] = '{16'h1111, 16'h5A5A, 16'h0000, 16'hC3C3, 16'h8001, 16'h4321};
    localparam logic [15:0] V_RD  [NV] = '{16'hBEE1, 16'h0F0F, 16'hFFFF, 16'h2468, 16'h1357, 16'h9ABC};

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_factor(input logic [3:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_factor = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // cfg_mode: 0 none, 1 write coincides with acceptance, 2 write + spurious request mid-access
    task automatic run_access(input int n, input logic wr, input logic [15:0] a,
                              input logic [15:0] wd, input logic [15:0] rd,
                              input int cfg_mode, input logic [3:0] cfg_val);
        int hi = 0;
        int lo = 0;
        logic order_ok = 1'b1;
        logic hold_ok = 1'b1;
        logic busy_ok = 1'b1;
        logic seen_low = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        per_rdata = rd;
        if (cfg_mode == 1) begin
            cfg_we = 1'b1;
            cfg_factor = cfg_val;
        end
        for (int k = 1; k <= 2 * n + 1; k++) begin
            @(negedge clk);
            if (k <= 2 * n) begin
                if (!busy) busy_ok = 1'b0;
                if (done) busy_ok = 1'b0;
                if (per_strobe_n) begin
                    hi++;
                    if (seen_low) order_ok = 1'b0;
                end else begin
                    lo++;
                    seen_low = 1'b1;
                end
                if (per_addr !== a || per_wdata !== wd || per_write !== wr) hold_ok = 1'b0;
            end
            if (k == 1) begin
                req_valid = 1'b0;
                cfg_we = 1'b0;
            end
            if (cfg_mode == 2 && k == 2) begin
                cfg_we = 1'b1;
                cfg_factor = cfg_val;
            end
            if (cfg_mode == 2 && k == 3) begin
                cfg_we = 1'b0;
                req_valid = 1'b1;
                req_addr = 16'hDEAD;
            end
            if (cfg_mode == 2 && k == 4) begin
                req_valid = 1'b0;
                req_addr = a;
            end
        end
        chk(hi == n, "R2 strobe-high cycles", hi, n);
        chk(lo == n, "R2 strobe-low cycles", lo, n);
        chk(order_ok, "R2 high phase precedes low phase", order_ok, 1);
        chk(hold_ok, "R7 address/data/direction held", hold_ok, 1);
        chk(busy_ok, "R5 busy throughout access", busy_ok, 1);
        chk(done === 1'b1 && busy === 1'b0, "R6 done pulse after low phase", {done, busy}, 2'b10);
        chk(rdata === rd, "R6 captured read data", rdata, rd);
        per_rdata = ~rd;
        @(negedge clk);
        chk(done === 1'b0, "R6 done lasts one cycle", done, 0);
        chk(rdata === rd, "R6 read data held", rdata, rd);
        chk(busy === 1'b0 && per_strobe_n === 1'b1, "R5 no extra access started",
            {busy, per_strobe_n}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(per_strobe_n === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset outputs",
            {per_strobe_n, busy, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 stored factor is 1 after reset
        run_access(1, 1'b0, 16'h0042, 16'h0000, 16'h7777, 0, 4'd0);

        for (int i = 0; i < NV; i++) begin
            set_factor(V_FAC[i]);   // R3 covered by the factor-0 vector
            run_access(V_N[i], V_WR[i], V_AD[i], V_WD[i], V_RD[i], 0, 4'd0);
        end

        // R4 write in the acceptance cycle: old factor 2 used, then 5
        set_factor(4'd2);
        run_access(2, 1'b1, 16'h0A0A, 16'hF00D, 16'h3C3C, 1, 4'd5);
        run_access(5, 1'b0, 16'h0B0B, 16'h0000, 16'hC0DE, 0, 4'd0);

        // R4/R5 write and spurious request mid-access: factor 4 kept, then 3
        set_factor(4'd4);
        run_access(4, 1'b0, 16'h0C0C, 16'h1357, 16'hABCD, 2, 4'd3);
        run_access(3, 1'b1, 16'h0D0D, 16'h2468, 16'h5555, 0, 4'd0);

        // R3 factor 0 again, back to back after a long access
        set_factor(4'd0);
        run_access(1, 1'b1, 16'h0E0E, 16'h9999, 16'h0001, 0, 4'd0);

        // R8 idle stays quiet
        repeat (4) @(negedge clk);
        chk(per_strobe_n === 1'b1 && busy === 1'b0, "R8 strobe high when idle",
            {per_strobe_n, busy}, 2'b10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule